// File: doc/BRIEF.md
# Adaptive Peak-Tracking Switch-Point Detector

This block turns a stream of signed, digitized samples of a differential sensor signal into a single digital level that follows the passing teeth and gaps of a rotating ferrous target. It keeps a running high peak and low peak of the signal. From their difference, the peak-to-peak span, it derives two switch thresholds: an upper one at about 70 % of the span above the low peak and a lower one at about 30 %. The output level flips when a sample passes a threshold, and it holds while the sample lies between the two thresholds.

The peaks follow any outward excursion of the signal at once. At each output transition they step inward by a bounded amount. The thresholds therefore follow a slowly shrinking or growing signal, and a single outlier sample does not pull them away. When the span becomes so small that it looks like vibration rather than target features, an amplitude lockout with its own hysteresis freezes the output. A sequencer enable can also freeze the output, while the peaks keep learning. Samples arrive with a one-cycle valid strobe. Every result is registered and visible the clock after the strobe.

Top module: `tooth_edge_detector`

## Requirements
- R1: While reset is held and in the first cycle after it, `lvl_out` is 1 (high-current level), `lock_o` is 1 and both peaks are 0. The output stays 1 until the first permitted threshold crossing.
- R2: On each valid sample, `peak_hi` becomes the sample if the sample exceeds it, and `peak_lo` becomes the sample if the sample is below it. `peak_hi >= peak_lo` at all times.
- R3: A valid sample that flips the output first moves each peak inward by step = max(span >> STEP_SHIFT, 1) (STEP_SHIFT = 6 by default), where span = peak_hi - peak_lo before the sample. The outward rule of R2 is then applied to the moved value. Peaks move inward at no other time.
- R4: The upper threshold is peak_lo + f(span), where f(s) = (s>>1)+(s>>3)+(s>>4)+(s>>6). When `lvl_out` is 1 and switching is permitted, a valid sample strictly greater than the upper threshold makes `lvl_out` 0. A sample equal to the threshold leaves it at 1.
- R5: The lower threshold is peak_hi - f(span). When `lvl_out` is 0 and switching is permitted, a valid sample strictly less than it makes `lvl_out` 1. A sample equal to the threshold leaves it at 0.
- R6: When `lock_o` is 0 and a valid sample arrives while the span is below LOCK_SET (170), `lock_o` becomes 1. While `lock_o` is 1 the output does not change.
- R7: When `lock_o` is 1, it clears only on a valid sample that arrives while the span is strictly above LOCK_CLR (200). A span of exactly 200 keeps it set.
- R8: While `run_en` is 0 the output holds its level, and the peaks keep updating per R2.
- R9: Every decision on a valid sample uses the peaks, lock flag and level from before that sample. All results appear on the ports on the next clock edge, and cycles without `smp_vld` change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample |
| smp_val | input | W (12) | Two's complement signal sample |
| run_en | input | 1 | Sequencer enable; 0 freezes the output level |
| lvl_out | output | 1 | Output level, 1 = high-current state |
| lock_o | output | 1 | Amplitude lockout active |
| peak_hi | output | W (12) | Tracked high peak, signed |
| peak_lo | output | W (12) | Tracked low peak, signed |

## Verification
The assertions assume that reset is held for at least one clock and that the peaks start equal. The ordering and inward-step properties depend on this. They also assume that the inputs are stable at the clock edge, so each strobe is seen exactly once. The stimulus drives all inputs on the falling edge and holds reset for several cycles. It uses triangle sweeps in steps of 10 that stay well inside the 12-bit range, so the span never approaches the width limit that the step and threshold arithmetic relies on.

// File: rtl/gpd_pkg.sv
package gpd_pkg;
   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } lvl_e;

   localparam int DEF_LOCK_SET = 170;
   localparam int DEF_LOCK_CLR = 200;
endpackage

// File: rtl/gpd_thresholds.sv
module gpd_thresholds #(
   parameter int W           = 12,
   parameter int STEP_SHIFT  = 6,
   parameter bit SYM_RELEASE = 1'b1
) (
   input  logic signed [W-1:0] pk_hi,
   input  logic signed [W-1:0] pk_lo,
   output logic        [W:0]   span,
   output logic signed [W-1:0] op_thr,
   output logic signed [W-1:0] rl_thr,
   output logic        [W:0]   step
);
   localparam int SW = W + 1;

   logic [W-1:0] f70;

   // span is non-negative because pk_hi >= pk_lo
   assign span = {pk_hi[W-1], pk_hi} - {pk_lo[W-1], pk_lo};

   // about 70 %: 1/2 + 1/8 + 1/16 + 1/64, each term truncated
   assign f70 = W'(span >> 1) + W'(span >> 3) + W'(span >> 4) + W'(span >> 6);

   // result lies between the peaks, so W-bit wrap-around arithmetic is exact
   assign op_thr = pk_lo + $signed(f70);

   generate
      if (SYM_RELEASE) begin : g_rel_sym
         assign rl_thr = pk_hi - $signed(f70);
      end else begin : g_rel_low
         logic [W-1:0] f30;
         assign f30    = W'(span >> 2) + W'(span >> 5) + W'(span >> 6);
         assign rl_thr = pk_lo + $signed(f30);
      end
   endgenerate

   assign step = ((span >> STEP_SHIFT) == '0) ? SW'(1) : (span >> STEP_SHIFT);
endmodule

// File: rtl/gpd_peak_tracker.sv
module gpd_peak_tracker #(
   parameter int W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vld,
   input  logic signed [W-1:0] smp,
   input  logic               shrink,
   input  logic        [W:0]   step,
   output logic signed [W-1:0] pk_hi,
   output logic signed [W-1:0] pk_lo
);
   localparam int XW = W + 2;

   logic signed [XW-1:0] smp_x, step_x, hi_in, lo_in;

   assign smp_x  = XW'(smp);
   assign step_x = $signed({1'b0, step});
   assign hi_in  = shrink ? (XW'(pk_hi) - step_x) : XW'(pk_hi);
   assign lo_in  = shrink ? (XW'(pk_lo) + step_x) : XW'(pk_lo);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pk_hi <= '0;
         pk_lo <= '0;
      end else if (vld) begin
         pk_hi <= (smp_x > hi_in) ? smp : hi_in[W-1:0];
         pk_lo <= (smp_x < lo_in) ? smp : lo_in[W-1:0];
      end
   end
endmodule

// File: rtl/gpd_lockout.sv
module gpd_lockout #(
   parameter int W        = 12,
   parameter int LOCK_SET = 170,
   parameter int LOCK_CLR = 200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vld,
   input  logic [W:0] span,
   output logic       locked
);
   localparam int         SW    = W + 1;
   localparam logic [W:0] SET_V = SW'(LOCK_SET);
   localparam logic [W:0] CLR_V = SW'(LOCK_CLR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked <= 1'b1;
      end else if (vld) begin
         if (locked && (span > CLR_V)) begin
            locked <= 1'b0;
         end else if (!locked && (span < SET_V)) begin
            locked <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/tooth_edge_detector.sv
module tooth_edge_detector
   import gpd_pkg::*;
#(
   parameter int W           = 12,
   parameter int STEP_SHIFT  = 6,
   parameter int LOCK_SET    = DEF_LOCK_SET,
   parameter int LOCK_CLR    = DEF_LOCK_CLR,
   parameter bit SYM_RELEASE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_vld,
   input  logic signed [W-1:0] smp_val,
   input  logic               run_en,
   output logic               lvl_out,
   output logic               lock_o,
   output logic signed [W-1:0] peak_hi,
   output logic signed [W-1:0] peak_lo
);
   generate
      if (W < 6 || W > 24) begin : g_bad_width
         $error("tooth_edge_detector: W must lie in 6..24");
      end
      if (STEP_SHIFT < 1 || STEP_SHIFT > W) begin : g_bad_shift
         $error("tooth_edge_detector: STEP_SHIFT must lie in 1..W");
      end
      if (LOCK_SET <= 0 || LOCK_SET >= LOCK_CLR) begin : g_bad_lock
         $error("tooth_edge_detector: need 0 < LOCK_SET < LOCK_CLR");
      end
      if (LOCK_CLR >= (1 << W)) begin : g_bad_clr
         $error("tooth_edge_detector: LOCK_CLR exceeds span range");
      end
   endgenerate

   logic        [W:0]   span, step;
   logic signed [W-1:0] op_thr, rl_thr;
   logic                locked;
   lvl_e                lvl_q;
   logic                may_switch, cross_up, cross_dn, flip;

   gpd_thresholds #(
      .W(W), .STEP_SHIFT(STEP_SHIFT), .SYM_RELEASE(SYM_RELEASE)
   ) thr_i (
      .pk_hi (peak_hi),
      .pk_lo (peak_lo),
      .span  (span),
      .op_thr(op_thr),
      .rl_thr(rl_thr),
      .step  (step)
   );

   gpd_lockout #(
      .W(W), .LOCK_SET(LOCK_SET), .LOCK_CLR(LOCK_CLR)
   ) lock_i (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (smp_vld),
      .span  (span),
      .locked(locked)
   );

   assign may_switch = run_en && !locked;
   assign cross_up   = (lvl_q == LVL_HIGH) && (smp_val > op_thr);
   assign cross_dn   = (lvl_q == LVL_LOW)  && (smp_val < rl_thr);
   assign flip       = smp_vld && may_switch && (cross_up || cross_dn);

   gpd_peak_tracker #(.W(W)) pk_i (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (smp_vld),
      .smp   (smp_val),
      .shrink(flip),
      .step  (step),
      .pk_hi (peak_hi),
      .pk_lo (peak_lo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= LVL_HIGH;
      end else if (flip) begin
         lvl_q <= (lvl_q == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
      end
   end

   assign lvl_out = (lvl_q == LVL_HIGH);
   assign lock_o  = locked;
endmodule

// File: rtl/gpd_checker.sv
module gpd_checker #(
   parameter int W          = 12,
   parameter int STEP_SHIFT = 6,
   parameter int LOCK_SET   = 170,
   parameter int LOCK_CLR   = 200
) (
   input logic               clk,
   input logic               rst_n,
   input logic               smp_vld,
   input logic               run_en,
   input logic               lvl_out,
   input logic               lock_o,
   input logic signed [W-1:0] peak_hi,
   input logic signed [W-1:0] peak_lo
);
   localparam int XW = W + 2;
   localparam int SW = W + 1;

   logic signed [XW-1:0] diff_c, prev_hi_x, prev_lo_x, prev_lim;
   logic signed [XW-1:0] lim_c, hi_drop, lo_rise;
   logic                 after_rst;

   assign diff_c  = XW'(peak_hi) - XW'(peak_lo);
   assign lim_c   = ((diff_c >>> STEP_SHIFT) == '0) ? XW'(1) : (diff_c >>> STEP_SHIFT);
   assign hi_drop = prev_hi_x - XW'(peak_hi);
   assign lo_rise = XW'(peak_lo) - prev_lo_x;

   always_ff @(posedge clk) begin
      after_rst <= !rst_n;
      prev_hi_x <= XW'(peak_hi);
      prev_lo_x <= XW'(peak_lo);
      prev_lim  <= lim_c;
   end

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      after_rst |-> (lvl_out && lock_o && peak_hi == '0 && peak_lo == '0));

   // R2
   peaks_ordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      diff_c >= 0);

   // R3
   hi_inward_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_drop > 0) |-> (hi_drop <= prev_lim && $past(smp_vld)));

   // R3
   lo_inward_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_rise > 0) |-> (lo_rise <= prev_lim && $past(smp_vld)));

   // R6
   lock_set_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> ((prev_hi_x - prev_lo_x) < XW'(LOCK_SET)));

   // R7
   lock_clr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_o) |-> ((prev_hi_x - prev_lo_x) > XW'(LOCK_CLR)));

   // R6
   lock_holds_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o |=> $stable(lvl_out));

   // R8
   enable_gates_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> $stable(lvl_out));

   // R9
   idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> ($stable(lvl_out) && $stable(lock_o) &&
                    $stable(peak_hi) && $stable(peak_lo)));

   logic unused_sw;
   assign unused_sw = (SW > 0);
endmodule

bind tooth_edge_detector gpd_checker #(
   .W(W), .STEP_SHIFT(STEP_SHIFT), .LOCK_SET(LOCK_SET), .LOCK_CLR(LOCK_CLR)
) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .smp_vld(smp_vld),
   .run_en (run_en),
   .lvl_out(lvl_out),
   .lock_o (lock_o),
   .peak_hi(peak_hi),
   .peak_lo(peak_lo)
);

// File: tb/tooth_edge_detector_tb_top.sv
module tooth_edge_detector_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 12;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                smp_vld;
   logic signed [W-1:0] smp_val;
   logic                run_en;
   logic                lvl_out, lock_o;
   logic signed [W-1:0] peak_hi, peak_lo;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   // reference model state
   int  m_hi, m_lo, m_edges;
   bit  m_out, m_lock;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tooth_edge_detector #(.W(W)) dut_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_vld(smp_vld),
      .smp_val(smp_val),
      .run_en (run_en),
      .lvl_out(lvl_out),
      .lock_o (lock_o),
      .peak_hi(peak_hi),
      .peak_lo(peak_lo)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int f70(input int s);
      return (s >> 1) + (s >> 3) + (s >> 4) + (s >> 6);
   endfunction

   function automatic int upper_thr();
      return m_lo + f70(m_hi - m_lo);
   endfunction

   function automatic int lower_thr();
      return m_hi - f70(m_hi - m_lo);
   endfunction

   function automatic int inward_step();
      int s;
      s = (m_hi - m_lo) >> 6;
      return (s == 0) ? 1 : s;
   endfunction

   // one valid sample, model update, then an idle cycle; compare at the ports
   task automatic push(input int s, input bit en);
      int  span, stp;
      bit  flip;
      span = m_hi - m_lo;
      stp  = inward_step();
      flip = !m_lock && en &&
             ((m_out && s > upper_thr()) || (!m_out && s < lower_thr()));
      if (m_lock && span > 200)       m_lock = 1'b0;
      else if (!m_lock && span < 170) m_lock = 1'b1;
      if (flip) begin
         m_hi  = (s > m_hi - stp) ? s : m_hi - stp;
         m_lo  = (s < m_lo + stp) ? s : m_lo + stp;
         m_out = !m_out;
         m_edges++;
      end else begin
         m_hi = (s > m_hi) ? s : m_hi;
         m_lo = (s < m_lo) ? s : m_lo;
      end
      @(negedge clk);
      smp_vld = 1'b1;
      smp_val = W'(s);
      run_en  = en;
      @(negedge clk);
      smp_vld = 1'b0;
      check("R9 level after sample", int'(lvl_out), int'(m_out));
      check("R6/R7 lock after sample", int'(lock_o), int'(m_lock));
      check("R2 high peak", int'(peak_hi), m_hi);
      check("R2 low peak", int'(peak_lo), m_lo);
   endtask

   task automatic sweep(input int amp, input bit en);
      for (int v = 0; v < amp; v += 10) push(v, en);
      for (int v = amp; v > -amp; v -= 10) push(v, en);
      for (int v = -amp; v < 0; v += 10) push(v, en);
   endtask

   task automatic t_reset();
      rst_n   = 1'b0;
      smp_vld = 1'b0;
      smp_val = '0;
      run_en  = 1'b1;
      m_hi = 0; m_lo = 0; m_out = 1'b1; m_lock = 1'b1; m_edges = 0;
      repeat (4) @(negedge clk);
      check("R1 reset level", int'(lvl_out), 1);
      check("R1 reset lock", int'(lock_o), 1);
      check("R1 reset high peak", int'(peak_hi), 0);
      check("R1 reset low peak", int'(peak_lo), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 idle keeps level", int'(lvl_out), 1);
      check("R9 idle keeps peaks", int'(peak_hi), 0);
   endtask

   task automatic t_vibration();
      sweep(60, 1'b1);
      sweep(60, 1'b1);
      check("R1 level held under small signal", int'(lvl_out), 1);
      check("R6 lock held under small signal", int'(lock_o), 1);
      check("R2 high peak follows", int'(peak_hi), 60);
      check("R2 low peak follows", int'(peak_lo), -60);
   endtask

   task automatic t_band_edge();
      sweep(100, 1'b1);
      sweep(100, 1'b1);
      check("R7 span 200 stays locked", int'(lock_o), 1);
      check("R7 span 200 level held", int'(lvl_out), 1);
      check("R7 span value", int'(peak_hi) - int'(peak_lo), 200);
   endtask

   task automatic t_unlock();
      int e0;
      e0 = m_edges;
      sweep(150, 1'b1);
      sweep(150, 1'b1);
      check("R7 lock released above 200", int'(lock_o), 0);
      check("R4 edges produced after release", int'(m_edges > e0), 1);
   endtask

   task automatic t_thresholds();
      int op, rl, hb, st;
      if (!m_out) push(m_lo, 1'b1);
      check("R5 level high before operate test", int'(lvl_out), 1);
      op = upper_thr();
      push(op, 1'b1);
      check("R4 sample equal to upper threshold holds", int'(lvl_out), 1);
      hb = m_hi;
      st = inward_step();
      push(op + 1, 1'b1);
      check("R4 sample above upper threshold switches", int'(lvl_out), 0);
      check("R3 high peak steps inward by one step", int'(peak_hi), hb - st);
      rl = lower_thr();
      push(rl, 1'b1);
      check("R5 sample equal to lower threshold holds", int'(lvl_out), 0);
      push(rl - 1, 1'b1);
      check("R5 sample below lower threshold switches", int'(lvl_out), 1);
   endtask

   task automatic t_enable_off();
      bit lv;
      lv = lvl_out;
      sweep(170, 1'b0);
      check("R8 level frozen with enable low", int'(lvl_out), int'(lv));
      check("R8 high peak still learns", int'(peak_hi), 170);
      check("R8 low peak still learns", int'(peak_lo), -170);
   endtask

   task automatic t_decay_lock();
      bit lv;
      for (int i = 0; i < 60 && !m_lock; i++) sweep(80, 1'b1);
      check("R6 lock set after span decays", int'(lock_o), 1);
      check("R6 span below set level", int'((int'(peak_hi) - int'(peak_lo)) < 170), 1);
      lv = lvl_out;
      sweep(80, 1'b1);
      sweep(80, 1'b1);
      check("R6 level held while locked", int'(lvl_out), int'(lv));
   endtask

   initial begin
      t_reset();
      t_vibration();
      t_band_edge();
      t_unlock();
      t_thresholds();
      t_enable_off();
      t_decay_lock();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule